// File: doc/BRIEF.md
# Prioritised Sixteen-Input Interrupt Controller

The controller watches sixteen interrupt request lines, synchronises each to the clock and turns every rising edge into a sticky pending flag. Each line carries a four-bit priority. Among the pending lines whose priority is non-zero, the controller picks the winner and presents it to the processor as a request strobe plus a four-bit index. It holds both until software writes the return register to say the request has been served. It then clears that line's flag, drops the request for one cycle and arbitrates again.

Software reaches the block through a byte-wide register port with combinational reads. The port holds eight priority registers with two nibbles each, two pending-flag registers and a mode register. The low pending register doubles as the return register. Besides normal continuous service, two mode settings let software admit exactly one more request, or let the request in service finish and then admit no more.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `cpu_req` and `cpu_idx` are 0, and every register (addresses 0 to 10) reads as 0.
- R2: Priority register k (address 0 to 7) holds input 2k in bits 3:0 and input 2k+1 in bits 7:4. It reads back what was written.
- R3: A rising edge on `irq_in[i]` sets pending flag i three clock edges after it is applied. Address 8 bit i shows inputs 0 to 7 and address 9 bit i-8 shows inputs 8 to 15. A flag stays set until its request is served.
- R4: An input with priority 0 still records its pending flag but never raises `cpu_req`. Once its priority is made non-zero, the stored flag can win arbitration.
- R5: The winner is the pending input with the largest non-zero priority. On equal priority the higher-numbered input wins.
- R6: `cpu_req` rises with `cpu_idx` set to the winner one edge after the winner becomes eligible. Until the served write, both stay unchanged even if a higher-priority input arrives or priorities change.
- R7: Any write to address 8 while `cpu_req` is high clears the served input's flag and drops `cpu_req` on the same edge, whatever the data. One edge later the next winner, if any, is raised.
- R8: A write to address 8 while `cpu_req` is low has no effect on any pending flag.
- R9: A line held high triggers once only. Further edges on an input that is already pending merge into the one flag and are served once.
- R10: The mode register is address 10, with bit 0 = normal and bit 1 = stop-after. With bit 0 set, requests are served continuously.
- R11: With mode 00 (the reset value, or written as 0) exactly one new request may be raised. After that no further request is raised until the mode register is written again.
- R12: Writing mode 10 (stop-after set, normal clear) lets the outstanding request keep its index until served. After that no new request is raised, and the remaining flags stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Asynchronous interrupt request lines, rising-edge sensitive |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| cpu_req | output | 1 | Request to the processor |
| cpu_idx | output | 4 | Index of the request being presented |

## Verification
An edge on a line becomes visible in the pending registers after the third clock edge and, if the line wins, on `cpu_req` after the fourth. The bench therefore drives each pulse on a falling edge and steps exactly that many falling edges before it reads or samples. A served write, a priority write or a mode write takes effect on the edge that takes the write, and any new request follows one edge later. So the bench checks the dropped request right after the write and the next winner one step after that. The random rounds load priorities and pulses while the stop-after mode blocks service, then switch to normal mode, so every winner the bench predicts is settled before arbitration starts.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and register layout of the interrupt controller.
// Assumes two priority nibbles per data byte and eight flags per pending byte.
package irqc_pkg;
    localparam int N_IRQ_DEF  = 16;
    localparam int PRIO_W_DEF = 4;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 4;

    // Decoded mode setting held by the register bank.
    typedef struct packed {
        logic stop_after;  // bit 1: finish current request, then admit none
        logic normal;      // bit 0: continuous service
    } irqc_mode_t;
endpackage

// File: rtl/irqc_edge_capture.sv
// Module: irqc_edge_capture
// Synchronises each asynchronous request line through two flops and
// emits a one-cycle pulse on every rising edge seen after synchronisation.
// Assumes request lines stay high for at least two clock periods.
module irqc_edge_capture #(
    parameter int N_IRQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_async,
    output logic [N_IRQ-1:0] rise
);
    localparam int DEPTH = 3;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic [DEPTH-1:0] sh_q;

        // Shift chain: two synchroniser stages plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[DEPTH-2:0], irq_async[g]};
            end
        end

        assign rise[g] = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
    end
endmodule

// File: rtl/irqc_pending.sv
// Module: irqc_pending
// Sticky pending flags: a rise sets a flag, a served clear resets it.
// A set and a clear on the same flag in the same cycle leave it set,
// so a fresh edge is never lost.
module irqc_pending #(
    parameter int N_IRQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] set_vec,
    input  logic [N_IRQ-1:0] clr_vec,
    output logic [N_IRQ-1:0] pend
);
    // Flag update: clear first, then OR in new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Module: irqc_arbiter
// Combinational priority pick over the pending flags. A zero priority
// excludes an input, larger values win, and ties go to the higher index.
// Assumes priorities arrive flattened, input i at bits [i*PRIO_W +: PRIO_W].
module irqc_arbiter #(
    parameter int N_IRQ  = 16,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]        pend,
    input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output logic                    pick_valid,
    output logic [IDX_W-1:0]        pick_idx
);
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] cur;

    // Linear scan from input 0 upward; ">=" hands ties to the later input.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        best       = '0;
        cur        = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            cur = prio_flat[i*PRIO_W +: PRIO_W];
            if (pend[i] && (cur != '0) && (cur >= best)) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
                best       = cur;
            end
        end
    end
endmodule

// File: rtl/irqc_service.sv
// Module: irqc_service
// Service handshake and single-service modes. Raises the request when
// idle and allowed, freezes the index until the served write, then drops
// the request for one cycle. An "armed" token limits admission outside
// normal mode: a mode write of 00 grants one token, 10 withdraws it.
module irqc_service #(
    parameter int N_IRQ = 16,
    parameter int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             served_wr,
    input  logic             mode_wr,
    input  logic             wr_normal,
    input  logic             wr_stop,
    input  logic             mode_normal,
    output logic             req,
    output logic [IDX_W-1:0] idx,
    output logic [N_IRQ-1:0] clr_vec
);
    logic armed_q;
    logic allowed;
    logic launch;
    logic served_hit;

    assign allowed    = mode_normal | armed_q;
    assign launch     = ~req & allowed & pick_valid;
    assign served_hit = req & served_wr;

    // Request and frozen index: launch when idle, drop on served write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
            idx <= '0;
        end else if (served_hit) begin
            req <= 1'b0;
        end else if (launch) begin
            req <= 1'b1;
            idx <= pick_idx;
        end
    end

    // Admission token: reloaded by mode writes, spent by a launch outside normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (mode_wr) begin
            armed_q <= wr_normal | ~wr_stop;
        end else if (launch && !mode_normal) begin
            armed_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_clr
        assign clr_vec[g] = served_hit && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/irqc_regs.sv
// Module: irqc_regs
// Byte-wide register bank: packed priority nibbles, two read-only pending
// bytes (the first also acts as the return register) and the mode byte.
// Reads are combinational; one write per cycle on reg_we.
module irqc_regs #(
    parameter int N_IRQ  = 16,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic                    reg_we,
    input  logic [N_IRQ-1:0]        pend,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output irqc_pkg::irqc_mode_t    mode,
    output logic                    served_wr,
    output logic                    mode_wr
);
    localparam int PER_REG    = DATA_W / PRIO_W;
    localparam int N_PRIO_REG = N_IRQ / PER_REG;
    localparam int N_PEND_REG = N_IRQ / DATA_W;
    localparam int A_RET      = N_PRIO_REG;
    localparam int A_MODE     = N_PRIO_REG + N_PEND_REG;

    assign served_wr = reg_we && (reg_addr == ADDR_W'(A_RET));
    assign mode_wr   = reg_we && (reg_addr == ADDR_W'(A_MODE));

    for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
        logic [PRIO_W-1:0] prio_q;

        // Priority nibble of input g, written through its packed register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (reg_we && (reg_addr == ADDR_W'(g / PER_REG))) begin
                prio_q <= reg_wdata[(g % PER_REG)*PRIO_W +: PRIO_W];
            end
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
    end

    // Mode byte: bit 0 normal, bit 1 stop-after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.normal     <= reg_wdata[0];
            mode.stop_after <= reg_wdata[1];
        end
    end

    // Read multiplexer over priority, pending and mode registers.
    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < N_PRIO_REG; r++) begin
            if (reg_addr == ADDR_W'(r)) begin
                reg_rdata = prio_flat[r*DATA_W +: DATA_W];
            end
        end
        for (int k = 0; k < N_PEND_REG; k++) begin
            if (reg_addr == ADDR_W'(A_RET + k)) begin
                reg_rdata = pend[k*DATA_W +: DATA_W];
            end
        end
        if (reg_addr == ADDR_W'(A_MODE)) begin
            reg_rdata[1:0] = {mode.stop_after, mode.normal};
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: irq_prio_ctrl (top)
// Prioritised interrupt controller: edge capture, pending flags, priority
// arbitration and a served-write handshake toward the processor.
// Assumes DATA_W is twice PRIO_W and N_IRQ is a multiple of DATA_W.
module irq_prio_ctrl #(
    parameter int N_IRQ  = irqc_pkg::N_IRQ_DEF,
    parameter int PRIO_W = irqc_pkg::PRIO_W_DEF,
    parameter int DATA_W = irqc_pkg::DATA_W_DEF,
    parameter int ADDR_W = irqc_pkg::ADDR_W_DEF,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_req,
    output logic [IDX_W-1:0]  cpu_idx
);
    logic [N_IRQ-1:0]        rise_vec;
    logic [N_IRQ-1:0]        clr_vec;
    logic [N_IRQ-1:0]        pend_q;
    logic [N_IRQ*PRIO_W-1:0] prio_flat;
    logic                    pick_valid;
    logic [IDX_W-1:0]        pick_idx;
    logic                    served_wr;
    logic                    mode_wr;
    irqc_pkg::irqc_mode_t    mode;

    irqc_edge_capture #(.N_IRQ(N_IRQ)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_async (irq_in),
        .rise      (rise_vec)
    );

    irqc_pending #(.N_IRQ(N_IRQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (rise_vec),
        .clr_vec (clr_vec),
        .pend    (pend_q)
    );

    irqc_regs #(
        .N_IRQ (N_IRQ),
        .PRIO_W(PRIO_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .pend      (pend_q),
        .reg_rdata (reg_rdata),
        .prio_flat (prio_flat),
        .mode      (mode),
        .served_wr (served_wr),
        .mode_wr   (mode_wr)
    );

    irqc_arbiter #(
        .N_IRQ (N_IRQ),
        .PRIO_W(PRIO_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .pend       (pend_q),
        .prio_flat  (prio_flat),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    irqc_service #(
        .N_IRQ(N_IRQ),
        .IDX_W(IDX_W)
    ) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pick_valid  (pick_valid),
        .pick_idx    (pick_idx),
        .served_wr   (served_wr),
        .mode_wr     (mode_wr),
        .wr_normal   (reg_wdata[0]),
        .wr_stop     (reg_wdata[1]),
        .mode_normal (mode.normal),
        .req         (cpu_req),
        .idx         (cpu_idx),
        .clr_vec     (clr_vec)
    );
endmodule

// File: rtl/irqc_checker.sv
// Module: irqc_checker
// Protocol properties of the controller, bound into the top module.
module irqc_checker #(
    parameter int N_IRQ  = 16,
    parameter int ADDR_W = 4,
    parameter int A_RET  = 8,
    parameter int IDX_W  = $clog2(N_IRQ)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              cpu_req,
    input logic [IDX_W-1:0]  cpu_idx,
    input logic [N_IRQ-1:0]  pend
);
    logic served;
    assign served = reg_we && (reg_addr == ADDR_W'(A_RET));

    // R1: leaving reset, no request is presented.
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cpu_req && cpu_idx == '0));

    // R3: flags only fall through a served write.
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && served) |=> ((pend & $past(pend)) == $past(pend)));

    // R4: a presented request always belongs to a pending input.
    p_req_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> pend[cpu_idx]);

    // R6: request and index hold until the served write.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !served) |=> (cpu_req && $stable(cpu_idx)));

    // R7: the served write drops the request on the next edge.
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && served) |=> !cpu_req);
endmodule

bind irq_prio_ctrl irqc_checker #(
    .N_IRQ (N_IRQ),
    .ADDR_W(ADDR_W),
    .A_RET (N_IRQ / (DATA_W / PRIO_W))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .cpu_req  (cpu_req),
    .cpu_idx  (cpu_idx),
    .pend     (pend_q)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic        cpu_req;
    logic [3:0]  cpu_idx;

    int checks = 0;
    int failures = 0;
    logic [3:0]  m_prio [16];
    logic [15:0] m_pend = '0;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .cpu_req(cpu_req), .cpu_idx(cpu_idx)
    );

    always #5 clk = ~clk;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_rd(input string rq, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(rq, $sformatf("read addr %0d", a), {24'd0, d}, {24'd0, exp});
    endtask

    task automatic chk_req(input string rq, input logic r, input logic [3:0] i);
        chk(rq, "cpu_req", {31'd0, cpu_req}, {31'd0, r});
        if (r) chk(rq, "cpu_idx", {28'd0, cpu_idx}, {28'd0, i});
    endtask

    // Pulse: ends between the second and third edge after the rise.
    task automatic pulse(input logic [15:0] m);
        irq_in = irq_in | m;
        step(2);
        irq_in = irq_in & ~m;
        m_pend = m_pend | m;
    endtask

    task automatic set_prio(input int i, input logic [3:0] v);
        int r;
        m_prio[i] = v;
        r = i / 2;
        wr(4'(r), {m_prio[2*r+1], m_prio[2*r]});
    endtask

    task automatic serve(input logic [7:0] d);
        wr(4'd8, d);
        if (cpu_idx < 16) m_pend[cpu_idx] = 1'b0;
    endtask

    function automatic int exp_winner();
        int w = -1;
        logic [3:0] best = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_pend[i] && m_prio[i] != 0 && m_prio[i] >= best) begin
                w = i; best = m_prio[i];
            end
        end
        return w;
    endfunction

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int w;
        logic [7:0] b;
        seed_init = $urandom(32'd2718);
        for (int i = 0; i < 16; i++) m_prio[i] = '0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk_req("R1", 1'b0, 4'd0);
        chk("R1", "cpu_idx", {28'd0, cpu_idx}, 32'd0);
        for (int a = 0; a <= 10; a++) chk_rd("R1", 4'(a), 8'h00);

        // R10: normal mode
        wr(4'd10, 8'h01);
        chk_rd("R10", 4'd10, 8'h01);

        // R2: nibble packing
        m_prio[6] = 4'h5; m_prio[7] = 4'hA;
        wr(4'd3, 8'hA5);
        chk_rd("R2", 4'd3, 8'hA5);

        // R3/R4: zero priority still records pending
        pulse(16'h1008);
        step(1);
        chk_rd("R3", 4'd8, 8'h08);
        chk_rd("R3", 4'd9, 8'h10);
        step(2);
        chk_req("R4", 1'b0, 4'd0);

        // R4/R6: enabling input 3 raises it one edge later
        set_prio(3, 4'h2);
        chk_req("R6", 1'b0, 4'd0);
        step(1);
        chk_req("R4", 1'b1, 4'd3);

        // R6: frozen despite higher priority arriving
        set_prio(12, 4'hF);
        step(1);
        chk_req("R6", 1'b1, 4'd3);
        pulse(16'h0200);
        step(2);
        chk_req("R6", 1'b1, 4'd3);

        // R7: served write clears, drops, re-arbitrates
        serve(8'h5A);
        chk_req("R7", 1'b0, 4'd0);
        chk_rd("R7", 4'd8, 8'h00);
        step(1);
        chk_req("R7", 1'b1, 4'd12);
        serve(8'h00);
        chk_req("R7", 1'b0, 4'd0);
        chk_rd("R4", 4'd9, 8'h02);
        step(1);
        chk_req("R4", 1'b0, 4'd0);

        // R8: served write while idle is ignored
        wr(4'd8, 8'hFF);
        chk_rd("R8", 4'd9, 8'h02);
        chk_rd("R8", 4'd8, 8'h00);

        // R5: tie goes to the higher input
        set_prio(5, 4'h7);
        set_prio(10, 4'h7);
        pulse(16'h0420);
        step(2);
        chk_req("R5", 1'b1, 4'd10);
        serve(8'h01);
        step(1);
        chk_req("R5", 1'b1, 4'd5);
        serve(8'h02);
        step(1);
        chk_req("R5", 1'b0, 4'd0);

        // R4: stored zero-priority flag served once enabled
        set_prio(9, 4'h1);
        step(1);
        chk_req("R4", 1'b1, 4'd9);
        serve(8'h03);
        step(1);
        chk_req("R4", 1'b0, 4'd0);

        // R9: held level triggers once; repeated edges merge
        set_prio(2, 4'h3);
        irq_in[2] = 1'b1;
        m_pend[2] = 1'b1;
        step(4);
        chk_req("R9", 1'b1, 4'd2);
        pulse(16'h0040);
        step(1);
        pulse(16'h0040);
        step(2);
        chk_req("R6", 1'b1, 4'd2);
        serve(8'h04);
        step(1);
        chk_req("R9", 1'b1, 4'd6);
        serve(8'h05);
        step(10);
        chk_req("R9", 1'b0, 4'd0);
        chk_rd("R9", 4'd8, 8'h00);
        irq_in[2] = 1'b0;
        step(3);

        // R11: single service
        wr(4'd10, 8'h00);
        pulse(16'h00C0);
        step(2);
        chk_req("R11", 1'b1, 4'd7);
        serve(8'h06);
        step(6);
        chk_req("R11", 1'b0, 4'd0);
        chk_rd("R11", 4'd8, 8'h40);
        wr(4'd10, 8'h00);
        step(1);
        chk_req("R11", 1'b1, 4'd6);
        serve(8'h07);
        step(1);
        chk_req("R11", 1'b0, 4'd0);

        // R12: stop after current
        wr(4'd10, 8'h01);
        pulse(16'h00C0);
        step(2);
        chk_req("R12", 1'b1, 4'd7);
        wr(4'd10, 8'h02);
        chk_req("R12", 1'b1, 4'd7);
        serve(8'h08);
        step(5);
        chk_req("R12", 1'b0, 4'd0);
        chk_rd("R12", 4'd8, 8'h40);
        wr(4'd10, 8'h01);
        step(1);
        chk_req("R10", 1'b1, 4'd6);
        serve(8'h09);
        step(1);
        chk_req("R10", 1'b0, 4'd0);

        // R5/R10: random rounds
        for (int it = 0; it < 40; it++) begin
            wr(4'd10, 8'h02);
            for (int r = 0; r < 8; r++) begin
                b = 8'($urandom);
                m_prio[2*r] = b[3:0];
                m_prio[2*r+1] = b[7:4];
                wr(4'(r), b);
            end
            pulse(16'($urandom));
            step(2);
            wr(4'd10, 8'h01);
            step(1);
            for (int k = 0; k < 18; k++) begin
                w = exp_winner();
                if (w < 0) begin
                    chk_req("R5", 1'b0, 4'd0);
                    break;
                end
                chk_req("R5", 1'b1, 4'(w));
                serve(8'($urandom));
                chk_req("R7", 1'b0, 4'd0);
                step(1);
            end
            chk_rd("R3", 4'd8, m_pend[7:0]);
            chk_rd("R3", 4'd9, m_pend[15:8]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule